// File: doc/BRIEF.md
# Reference-Timed Data Rate Meter

This block estimates the rate of an event stream, typically one strobe per recovered bit, by counting those events over a gate window timed by a reference clock of known frequency. Both streams arrive as single-cycle strobes on one system clock. The gate lasts 2^(BASE_EXP + k) reference strobes, where k comes from a 2-bit range code describing the reference band. The count is therefore pre-normalised, and the rate in Mb/s equals count × f_ref(MHz) / 2^(BASE_EXP + k). With BASE_EXP = 14 and a 32 MHz reference on the 20–40 MHz code, a 622.08 Mb/s stream reads 637009 (0x9B851).

A measurement is armed by driving the restart input high and then low while the enable level is held high. Enable may stay high across any number of measurements. While a window runs, the done flag reads 0 and the previous result stays visible. When the window closes, the 23-bit count, the done flag and the saturation flag all update in the same cycle. The result is split over three byte-wide outputs. The reading is flagged valid only while the loss-of-lock input is low.

Top module: `rate_meter`

## Requirements
- R1: The gate window lasts 2^(BASE_EXP+k) reference strobes, where k = 0 for range code 2'b00, k = 1 for 2'b01, and k = 2 for 2'b10; code 2'b11 behaves exactly like 2'b10.
- R2: The result equals the number of cycles with meas_tick_i high, counted from the first cycle after the clock edge that samples restart_i low through the cycle carrying the final reference strobe, inclusive.
- R3: A measurement starts only after restart_i is sampled high and then sampled low on a later edge; counting begins in the cycle after that low sample.
- R4: done_o reads 0 from the edge after restart_i is sampled high until the window of the following measurement completes.
- R5: done_o rises in the cycle after the final reference strobe, stays high until the next restart, and measurements repeat with enable_i held high throughout.
- R6: freq_hi_o[6:0] carries result bits 22..16 and freq_hi_o[7] is 0; freq_mid_o carries bits 15..8; freq_lo_o carries bits 7..0.
- R7: valid_o is high exactly when done_o is high and lol_i is low, with no cycle of delay.
- R8: The event count saturates at CNT_MAX instead of wrapping. overflow_o reports, together with the result, whether saturation was reached, and it clears when restart_i is sampled high.
- R9: The three result outputs keep the last completed value while a new measurement runs, and they change only in the cycle in which done_o rises.
- R10: If restart_i is high in the cycle of the final reference strobe, the count is discarded: done_o stays 0 and the result outputs are unchanged.
- R11: While enable_i is low, no measurement completes: a restart pulse leaves done_o at 0, and a running window is abandoned.
- R12: The range code is captured when the measurement starts; changing range_sel_i during a window does not change the window length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One-cycle strobe per reference clock period |
| meas_tick_i | input | 1 | One-cycle strobe per measured event |
| range_sel_i | input | 2 | Reference band code: 00, 01, 10 (11 acts as 10) |
| enable_i | input | 1 | Measurement enable level |
| restart_i | input | 1 | Restart control; high then low arms a new window |
| lol_i | input | 1 | Loss-of-lock indication, high means unlocked |
| done_o | output | 1 | Sticky completion flag |
| valid_o | output | 1 | Result is complete and lock is held |
| overflow_o | output | 1 | Count saturated during the last completed window |
| freq_hi_o | output | 8 | Result bits 22..16 in bits 6..0 |
| freq_mid_o | output | 8 | Result bits 15..8 |
| freq_lo_o | output | 8 | Result bits 7..0 |

## Verification
A restart sampled high clears done_o at the next edge. The low sample that follows moves the block into counting, so the bench releases restart one cycle before it starts its own tick schedule and counts only the strobes it drives from then on. The result, done_o and overflow_o all appear one edge after the final reference strobe. The driver therefore records the cycle number of that strobe plus one in each scoreboard entry, and the monitor, sampling on the falling edge, checks the value and that exact cycle when done_o rises. valid_o follows lol_i combinationally and is checked within the same cycle the bench changes lol_i.

// File: rtl/rate_meter_pkg.sv
package rate_meter_pkg;
  localparam int unsigned FREQ_W = 23;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } meas_state_e;

  // range code -> extra window exponent; 2'b11 aliases 2'b10
  function automatic int unsigned range_exp_add(logic [1:0] code);
    case (code)
      2'b00:   return 0;
      2'b01:   return 1;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/rm_window_timer.sv
module rm_window_timer import rate_meter_pkg::*; #(
  parameter int unsigned BASE_EXP = 14
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       count_en_i,
  input  logic       ref_tick_i,
  input  logic [1:0] code_i,
  output logic       last_o
);
  localparam int unsigned TW = BASE_EXP + 3;
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] lim;

  always_comb lim = (ONE << (BASE_EXP + range_exp_add(code_i))) - ONE;

  assign last_o = count_en_i & ref_tick_i & (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clear_i)                  cnt_q <= '0;
    else if (count_en_i && ref_tick_i) cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/rm_event_counter.sv
module rm_event_counter #(
  parameter int unsigned W   = 23,
  parameter int unsigned MAX = (1 << 23) - 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         count_en_i,
  input  logic         tick_i,
  output logic [W-1:0] next_o,
  output logic         hit_o
);
  localparam logic [W-1:0] MAX_V = W'(MAX);

  logic [W-1:0] cnt_q;

  assign hit_o  = count_en_i & tick_i & (cnt_q == MAX_V);
  assign next_o = (count_en_i && tick_i && !hit_o) ? cnt_q + W'(1) : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else              cnt_q <= next_o;
  end
endmodule

// File: rtl/rm_result_regs.sv
module rm_result_regs #(
  parameter int unsigned W = 23
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  output logic [7:0]   hi_o,
  output logic [7:0]   mid_o,
  output logic [7:0]   lo_o
);
  localparam int unsigned LANES = (W + 7) / 8;
  localparam int unsigned PW    = LANES * 8;

  logic [PW-1:0] val_q;
  logic [7:0]    lane [LANES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (load_i) val_q <= PW'(value_i);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = val_q[g*8 +: 8];
  end

  assign lo_o  = lane[0];
  assign mid_o = lane[1];
  assign hi_o  = lane[2];
endmodule

// File: rtl/rate_meter.sv
module rate_meter import rate_meter_pkg::*; #(
  parameter int unsigned BASE_EXP = 14,
  parameter int unsigned CNT_MAX  = (1 << 23) - 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_tick_i,
  input  logic       meas_tick_i,
  input  logic [1:0] range_sel_i,
  input  logic       enable_i,
  input  logic       restart_i,
  input  logic       lol_i,
  output logic       done_o,
  output logic       valid_o,
  output logic       overflow_o,
  output logic [7:0] freq_hi_o,
  output logic [7:0] freq_mid_o,
  output logic [7:0] freq_lo_o
);
  meas_state_e       state_q, state_d;
  logic [1:0]        code_q;
  logic              run, last, load;
  logic              done_q, ovf_q, run_ovf_q, hit, ovf_next;
  logic [FREQ_W-1:0] cnt_next;

  assign run      = (state_q == ST_RUN) & enable_i & ~restart_i;
  assign load     = run & last;
  assign ovf_next = run_ovf_q | hit;

  always_comb begin
    state_d = state_q;
    if (restart_i) state_d = ST_ARMED;
    else begin
      case (state_q)
        ST_ARMED: state_d = enable_i ? ST_RUN : ST_IDLE;
        ST_RUN:   if (!enable_i || last) state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      code_q    <= 2'b00;
      done_q    <= 1'b0;
      ovf_q     <= 1'b0;
      run_ovf_q <= 1'b0;
    end else begin
      state_q <= state_d;
      // range captured as the window opens
      if (state_q == ST_ARMED && !restart_i) code_q <= range_sel_i;
      if (restart_i) begin
        done_q    <= 1'b0;
        ovf_q     <= 1'b0;
        run_ovf_q <= 1'b0;
      end else begin
        if (hit)  run_ovf_q <= 1'b1;
        if (load) begin
          done_q <= 1'b1;
          ovf_q  <= ovf_next;
        end
      end
    end
  end

  rm_window_timer #(.BASE_EXP(BASE_EXP)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (restart_i),
    .count_en_i (run),
    .ref_tick_i (ref_tick_i),
    .code_i     (code_q),
    .last_o     (last)
  );

  rm_event_counter #(.W(FREQ_W), .MAX(CNT_MAX)) u_events (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (restart_i),
    .count_en_i (run),
    .tick_i     (meas_tick_i),
    .next_o     (cnt_next),
    .hit_o      (hit)
  );

  rm_result_regs #(.W(FREQ_W)) u_result (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .value_i (cnt_next),
    .hi_o    (freq_hi_o),
    .mid_o   (freq_mid_o),
    .lo_o    (freq_lo_o)
  );

  assign done_o     = done_q;
  assign valid_o    = done_q & ~lol_i;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/rate_meter_chk.sv
module rate_meter_chk #(
  parameter int unsigned CNT_MAX = (1 << 23) - 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ref_tick_i,
  input logic       enable_i,
  input logic       restart_i,
  input logic       lol_i,
  input logic       done_o,
  input logic       valid_o,
  input logic       overflow_o,
  input logic [7:0] freq_hi_o,
  input logic [7:0] freq_mid_o,
  input logic [7:0] freq_lo_o
);
  logic [23:0] res;
  assign res = {freq_hi_o, freq_mid_o, freq_lo_o};

  AST_DONE_CLR_ON_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !done_o); // R4
  AST_DONE_AFTER_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(ref_tick_i)); // R5
  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lol_i |-> !valid_o); // R7
  AST_RESULT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res <= 24'(CNT_MAX)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !restart_i) |=> overflow_o); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res) |-> $rose(done_o)); // R9
  AST_NO_DONE_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !done_o) |=> !done_o); // R11
endmodule

bind rate_meter rate_meter_chk #(.CNT_MAX(CNT_MAX)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ref_tick_i (ref_tick_i),
  .enable_i   (enable_i),
  .restart_i  (restart_i),
  .lol_i      (lol_i),
  .done_o     (done_o),
  .valid_o    (valid_o),
  .overflow_o (overflow_o),
  .freq_hi_o  (freq_hi_o),
  .freq_mid_o (freq_mid_o),
  .freq_lo_o  (freq_lo_o)
);

// File: tb/tb_rate_meter.sv
`timescale 1ns/1ps
module tb_rate_meter;
  localparam int BASE = 3;
  localparam int CMAX = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0, meas_tick = 1'b0;
  logic [1:0] range_sel = 2'b00;
  logic       enable = 1'b0, restart = 1'b0, lol = 1'b0;
  logic       done_o, valid_o, overflow_o;
  logic [7:0] freq_hi_o, freq_mid_o, freq_lo_o;

  rate_meter #(.BASE_EXP(BASE), .CNT_MAX(CMAX)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .meas_tick_i(meas_tick),
    .range_sel_i(range_sel), .enable_i(enable), .restart_i(restart), .lol_i(lol),
    .done_o(done_o), .valid_o(valid_o), .overflow_o(overflow_o),
    .freq_hi_o(freq_hi_o), .freq_mid_o(freq_mid_o), .freq_lo_o(freq_lo_o)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int    count;
    int    cyc;
    bit    ovf;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0, errors = 0;
  int   last_val = 0;
  bit   done_seen = 1'b0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int result_now();
    return {freq_hi_o[6:0], freq_mid_o, freq_lo_o};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // monitor: compare on each rising done
  always @(negedge clk) begin
    if (rst_n && done_o && !done_seen) begin
      if (q.size() == 0) begin
        check(1'b0, "R10", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(result_now() == e.count, e.tag, "result", result_now(), e.count);
        check(freq_hi_o[7] == 1'b0 && freq_mid_o == 8'((e.count >> 8) & 255) &&
              freq_lo_o == 8'(e.count & 255), "R6", "byte split",
              {freq_hi_o, freq_mid_o, freq_lo_o}, e.count);
        check(cyc == e.cyc, "R5", "done cycle", cyc, e.cyc);
        check(overflow_o == e.ovf, "R8", "overflow", overflow_o, e.ovf);
        check(valid_o == !lol, "R7", "valid at done", valid_o, !lol);
        last_val = e.count;
      end
    end
    done_seen = done_o;
  end

  function automatic int win_len(input logic [1:0] sel);
    return 1 << (BASE + ((sel == 2'b00) ? 0 : (sel == 2'b01) ? 1 : 2));
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic run_meas(input logic [1:0] sel, input int rp, input int mp,
                          input logic [1:0] sel_mid, input bit discard,
                          input string tag);
    int n, rc, mc, i;
    range_sel = sel;
    restart = 1'b1;
    step();
    restart = 1'b0;
    step();
    check(done_o == 1'b0, "R4", "done cleared", done_o, 0);
    check(result_now() == last_val, "R9", "held result", result_now(), last_val);
    check(overflow_o == 1'b0, "R8", "overflow cleared", overflow_o, 0);
    n = win_len(sel);
    rc = 0; mc = 0; i = 0;
    while (rc < n) begin
      bit r, m;
      if (i == 1) range_sel = sel_mid;
      r = (i % rp) == rp - 1;
      m = (i % mp) == 0;
      if (m) mc++;
      if (r) rc++;
      ref_tick = r;
      meas_tick = m;
      if (rc == n) begin
        if (discard) restart = 1'b1;
        else begin
          exp_t e;
          e.count = (mc > CMAX) ? CMAX : mc;
          e.cyc   = cyc + 1;
          e.ovf   = mc > CMAX;
          e.tag   = tag;
          q.push_back(e);
        end
      end
      step();
      i++;
    end
    ref_tick = 1'b0;
    meas_tick = 1'b0;
    if (discard) begin
      step();
      check(done_o == 1'b0, "R10", "done after discard", done_o, 0);
      check(result_now() == last_val, "R10", "result after discard", result_now(), last_val);
      enable = 1'b0;
      restart = 1'b0;
      step();
      enable = 1'b1;
    end
    repeat (3) step();
  endtask

  initial begin
    repeat (4) step();
    check(done_o == 0 && valid_o == 0, "R5", "reset flags", {done_o, valid_o}, 0);
    check(overflow_o == 0, "R8", "reset overflow", overflow_o, 0);
    check(result_now() == 0, "R6", "reset result", result_now(), 0);
    rst_n = 1'b1;
    enable = 1'b1;
    step();

    run_meas(2'b00, 1, 1, 2'b00, 0, "R1 code00");
    run_meas(2'b01, 2, 3, 2'b01, 0, "R2 code01");
    run_meas(2'b10, 3, 2, 2'b10, 0, "R3 code10");
    run_meas(2'b11, 1, 2, 2'b11, 0, "R1 code11");
    run_meas(2'b00, 1, 1, 2'b10, 0, "R12 range change");

    // R7: lock loss masks valid immediately
    lol = 1'b1;
    #1;
    check(valid_o == 0 && done_o == 1, "R7", "valid with lol", valid_o, 0);
    lol = 1'b0;
    #1;
    check(valid_o == 1, "R7", "valid relocked", valid_o, 1);
    step();

    run_meas(2'b10, 10, 1, 2'b10, 0, "R8 saturate");
    run_meas(2'b10, 9, 1, 2'b10, 0, "R6 mid byte");
    run_meas(2'b00, 1, 1, 2'b00, 1, "R10 discard");

    // R11: restart with enable low, then a full window of ticks
    enable = 1'b0;
    restart = 1'b1;
    step();
    restart = 1'b0;
    ref_tick = 1'b1;
    meas_tick = 1'b1;
    repeat (40) step();
    check(done_o == 0, "R11", "done with enable low", done_o, 0);
    check(result_now() == last_val, "R11", "result with enable low", result_now(), last_val);
    // R11: enable dropped mid window
    enable = 1'b1;
    ref_tick = 1'b0;
    restart = 1'b1;
    step();
    restart = 1'b0;
    step();
    ref_tick = 1'b1;
    repeat (3) step();
    enable = 1'b0;
    repeat (20) step();
    enable = 1'b1;
    repeat (20) step();
    check(done_o == 0, "R11", "done after abort", done_o, 0);
    ref_tick = 1'b0;
    meas_tick = 1'b0;
    step();

    run_meas(2'b01, 1, 1, 2'b01, 0, "R3 after abort");
    check(q.size() == 0, "R5", "pending results", q.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule